// File: doc/BRIEF.md
# Resistor-Code Key Debouncer and Classifier

The block watches a stream of 8-bit conversion results taken from a single sense line. A resistor switched onto that line by a remote pushbutton moves the result into one of thirty narrow code windows. A plugged-in accessory with no key pressed gives its own window, and an open line sits at the top of the scale. Each sample is mapped to a class: one of thirty keys, jack present, jack absent, or invalid for a code in the gaps between windows. A code that falls in a gap is never reported.

A classified change is reported only after it has stayed put for a set number of millisecond ticks, 18 by default. The report is a one-cycle strobe that carries the new class and key number, and it feeds a key-event queue further down the chip. Shorter excursions count as contact chatter and are dropped. Pulling the active-low shutdown input low halts detection and returns the remembered state to "jack absent".

The controller has four states.
- S_OFF is held while shutdown is active. It leaves to S_WATCH on the first cycle after shutdown is released.
- S_WATCH compares each valid sample with the last reported class. A different valid class moves it to S_QUAL, carrying that class as the candidate.
- S_QUAL counts ticks. A sample equal to the reported class sends it back to S_WATCH, which is the chatter case. A different valid class replaces the candidate and restarts the count. An invalid sample only restarts the count. The tick that completes the count moves it to S_EMIT.
- S_EMIT drives the strobe for one cycle and then behaves as S_WATCH does.

Top module: `rcode_debouncer`

## Requirements
- R1: A code inside key window i, for example 0..1 for key 0, 11..13 for key 1, 123..127 for key 15 and 235..237 for key 29, is reported with evt_kind = 0 and evt_key = i. The thirty windows come from a table of low and high bounds.
- R2: A new class is reported only after STABLE_MS (default 18) ms_tick pulses have been seen while it is the candidate. The sample that opens the candidate does not count. The strobe is visible in the cycle after the clock edge that samples the last of those ticks.
- R3: If the reported class returns before the count completes, the candidate is dropped and no event is produced.
- R4: Codes 243..245 are reported as jack present (evt_kind = 1) and codes 254..255 as jack absent (evt_kind = 2). In both cases evt_key = 0.
- R5: A code outside every window is invalid. It never produces an event, and during qualification it restarts the tick count without dropping the candidate.
- R6: Any change of class produces an event. This includes key to key, key to jack present, and jack absent to key.
- R7: evt_vld is high for exactly one cycle per event.
- R8: After reset, and after shutdown is released, the reported class is jack absent. While shdn_n is low, no events are produced and any running count is lost.
- R9: A different valid class that arrives during qualification becomes the new candidate and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Active-low shutdown; halts detection |
| code_vld | input | 1 | Conversion sample strobe |
| code | input | 8 | Conversion result |
| ms_tick | input | 1 | One-cycle millisecond tick |
| evt_vld | output | 1 | One-cycle event strobe |
| evt_kind | output | 2 | 0 key, 1 jack present, 2 jack absent |
| evt_key | output | 5 | Key index for key events, else 0 |

## Verification
When a sample and a tick arrive together on every cycle, an event is due right after the 19th clock edge of a steady segment. The first edge only opens the candidate, and the next 18 edges count ticks. After a shutdown pulse the event is due one edge later, because the exit from S_OFF takes one edge. The bench changes inputs on the falling edge and reads evt_vld just after each rising edge. For every segment it records the index of the first strobe and the number of strobes, then compares both with the exact cycle the requirement gives. In the chatter, invalid and shutdown segments the expected number of strobes is zero.

// File: rtl/rkd_pkg.sv
package rkd_pkg;

    localparam int KEY_W = 5;

    typedef enum logic [1:0] {
        CK_KEY  = 2'd0,
        CK_JIN  = 2'd1,
        CK_JOUT = 2'd2,
        CK_BAD  = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic [KEY_W-1:0] key;
    } cls_t;

    localparam cls_t CLS_REST = '{kind: CK_JOUT, key: '0};

    // window bounds, key 29 in the top byte down to key 0 in the bottom byte
    localparam logic [30*8-1:0] WIN_LO_DEF = {
        8'd235, 8'd226, 8'd218, 8'd211, 8'd202, 8'd194, 8'd186, 8'd178,
        8'd170, 8'd162, 8'd154, 8'd146, 8'd137, 8'd130, 8'd123, 8'd114,
        8'd105, 8'd98,  8'd90,  8'd82,  8'd74,  8'd66,  8'd58,  8'd50,
        8'd42,  8'd35,  8'd27,  8'd19,  8'd11,  8'd0
    };
    localparam logic [30*8-1:0] WIN_HI_DEF = {
        8'd237, 8'd229, 8'd222, 8'd214, 8'd206, 8'd198, 8'd190, 8'd182,
        8'd174, 8'd166, 8'd159, 8'd150, 8'd142, 8'd135, 8'd127, 8'd119,
        8'd110, 8'd102, 8'd94,  8'd86,  8'd78,  8'd70,  8'd62,  8'd53,
        8'd46,  8'd38,  8'd30,  8'd21,  8'd13,  8'd1
    };

endpackage

// File: rtl/rkd_classifier.sv
module rkd_classifier
    import rkd_pkg::*;
#(
    parameter int                NKEYS   = 30,
    parameter logic [NKEYS*8-1:0] WIN_LO = WIN_LO_DEF,
    parameter logic [NKEYS*8-1:0] WIN_HI = WIN_HI_DEF,
    parameter logic [7:0]        JIN_LO  = 8'd243,
    parameter logic [7:0]        JIN_HI  = 8'd245,
    parameter logic [7:0]        JOUT_LO = 8'd254,
    parameter logic [7:0]        JOUT_HI = 8'd255
) (
    input  logic [7:0] code,
    output cls_t       cls
);

    logic [NKEYS-1:0] hit;

    // every window compared at once
    for (genvar i = 0; i < NKEYS; i++) begin : g_win
        assign hit[i] = (code >= WIN_LO[i*8 +: 8]) && (code <= WIN_HI[i*8 +: 8]);
    end

    always_comb begin
        cls = '{kind: CK_BAD, key: '0};
        for (int i = 0; i < NKEYS; i++) begin
            if (hit[i]) begin
                cls = '{kind: CK_KEY, key: KEY_W'(i)};
            end
        end
        if (code >= JIN_LO && code <= JIN_HI) begin
            cls = '{kind: CK_JIN, key: '0};
        end
        if (code >= JOUT_LO && code <= JOUT_HI) begin
            cls = '{kind: CK_JOUT, key: '0};
        end
    end

endmodule

// File: rtl/rkd_tick_timer.sv
module rkd_tick_timer #(
    parameter int LIMIT = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // true while the next tick is the one that completes the window
    assign last = (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/rkd_debounce_fsm.sv
module rkd_debounce_fsm
    import rkd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic shdn_n,
    input  logic smp_vld,
    input  cls_t smp_cls,
    input  logic tick,
    input  logic tmr_last,
    output logic tmr_clr,
    output logic tmr_inc,
    output logic evt_vld,
    output cls_t evt_cls
);

    typedef enum logic [1:0] {
        S_OFF   = 2'd0,
        S_WATCH = 2'd1,
        S_QUAL  = 2'd2,
        S_EMIT  = 2'd3
    } state_e;

    state_e state_q, state_d;
    cls_t   cand_q, cand_d;
    cls_t   rep_q, rep_d;

    logic smp_good;
    assign smp_good = smp_vld && (smp_cls.kind != CK_BAD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_WATCH;
            cand_q  <= CLS_REST;
            rep_q   <= CLS_REST;
        end else begin
            state_q <= state_d;
            cand_q  <= cand_d;
            rep_q   <= rep_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cand_d  = cand_q;
        rep_d   = rep_q;
        tmr_clr = 1'b0;
        tmr_inc = 1'b0;
        if (!shdn_n) begin
            state_d = S_OFF;
            rep_d   = CLS_REST;
            tmr_clr = 1'b1;
        end else begin
            unique case (state_q)
                S_OFF: begin
                    state_d = S_WATCH;
                end
                S_WATCH, S_EMIT: begin
                    state_d = S_WATCH;
                    if (smp_good && smp_cls != rep_q) begin
                        cand_d  = smp_cls;
                        tmr_clr = 1'b1;
                        state_d = S_QUAL;
                    end
                end
                S_QUAL: begin
                    if (smp_vld && !smp_good) begin
                        tmr_clr = 1'b1;
                    end else if (smp_vld && smp_cls == rep_q) begin
                        tmr_clr = 1'b1;
                        state_d = S_WATCH;
                    end else if (smp_vld && smp_cls != cand_q) begin
                        cand_d  = smp_cls;
                        tmr_clr = 1'b1;
                    end else if (tick) begin
                        if (tmr_last) begin
                            rep_d   = cand_q;
                            tmr_clr = 1'b1;
                            state_d = S_EMIT;
                        end else begin
                            tmr_inc = 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_comb begin
        evt_vld = (state_q == S_EMIT);
        evt_cls = rep_q;
    end

endmodule

// File: rtl/rcode_debouncer.sv
module rcode_debouncer
    import rkd_pkg::*;
#(
    parameter int                 NKEYS     = 30,
    parameter int                 STABLE_MS = 18,
    parameter logic [NKEYS*8-1:0] WIN_LO    = WIN_LO_DEF,
    parameter logic [NKEYS*8-1:0] WIN_HI    = WIN_HI_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shdn_n,
    input  logic             code_vld,
    input  logic [7:0]       code,
    input  logic             ms_tick,
    output logic             evt_vld,
    output logic [1:0]       evt_kind,
    output logic [KEY_W-1:0] evt_key
);

    cls_t smp_cls;
    cls_t evt_cls;
    logic tmr_clr, tmr_inc, tmr_last;

    rkd_classifier #(
        .NKEYS (NKEYS),
        .WIN_LO(WIN_LO),
        .WIN_HI(WIN_HI)
    ) u_cls (
        .code(code),
        .cls (smp_cls)
    );

    rkd_tick_timer #(
        .LIMIT(STABLE_MS)
    ) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tmr_clr),
        .inc  (tmr_inc),
        .last (tmr_last)
    );

    rkd_debounce_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .shdn_n  (shdn_n),
        .smp_vld (code_vld),
        .smp_cls (smp_cls),
        .tick    (ms_tick),
        .tmr_last(tmr_last),
        .tmr_clr (tmr_clr),
        .tmr_inc (tmr_inc),
        .evt_vld (evt_vld),
        .evt_cls (evt_cls)
    );

    assign evt_kind = evt_cls.kind;
    assign evt_key  = evt_cls.key;

endmodule

// File: rtl/rcode_debouncer_chk.sv
module rcode_debouncer_chk #(
    parameter int NKEYS     = 30,
    parameter int STABLE_MS = 18
) (
    input logic       clk,
    input logic       rst_n,
    input logic       shdn_n,
    input logic       ms_tick,
    input logic       evt_vld,
    input logic [1:0] evt_kind,
    input logic [4:0] evt_key
);

    localparam int GW = $clog2(STABLE_MS + 1);

    // ticks seen since the previous event or shutdown, saturating
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (evt_vld || !shdn_n) begin
            gap_q <= '0;
        end else if (ms_tick && gap_q != GW'(STABLE_MS)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_vld |=> !evt_vld); // R7
    AST_SHDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |=> !evt_vld); // R8
    AST_NO_BAD_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        evt_vld |-> evt_kind != 2'd3); // R5
    AST_KEY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vld && evt_kind == 2'd0) |-> evt_key < 5'(NKEYS)); // R1
    AST_JACK_KEY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vld && evt_kind != 2'd0) |-> evt_key == 5'd0); // R4
    AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        evt_vld |-> gap_q >= GW'(STABLE_MS)); // R2

endmodule

bind rcode_debouncer rcode_debouncer_chk #(
    .NKEYS    (NKEYS),
    .STABLE_MS(STABLE_MS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .shdn_n  (shdn_n),
    .ms_tick (ms_tick),
    .evt_vld (evt_vld),
    .evt_kind(evt_kind),
    .evt_key (evt_key)
);

// File: tb/rcode_debouncer_bench.sv
module rcode_debouncer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shdn_n = 1'b1;
    logic       code_vld = 1'b0;
    logic [7:0] code = 8'd255;
    logic       ms_tick = 1'b0;
    logic       evt_vld;
    logic [1:0] evt_kind;
    logic [4:0] evt_key;

    int n_run = 0;
    int n_fail = 0;
    int seg_evts, seg_first, seg_kind, seg_key;
    bit done = 0;

    always #10 clk = ~clk;

    rcode_debouncer u_rcode_debouncer (
        .clk     (clk),
        .rst_n   (rst_n),
        .shdn_n  (shdn_n),
        .code_vld(code_vld),
        .code    (code),
        .ms_tick (ms_tick),
        .evt_vld (evt_vld),
        .evt_kind(evt_kind),
        .evt_key (evt_key)
    );

    // {code, kind, key}; each row differs from the one before it
    localparam logic [14:0] VEC [12] = '{
        {8'd0,   2'd0, 5'd0},
        {8'd12,  2'd0, 5'd1},
        {8'd20,  2'd0, 5'd2},
        {8'd30,  2'd0, 5'd3},
        {8'd125, 2'd0, 5'd15},
        {8'd243, 2'd1, 5'd0},
        {8'd237, 2'd0, 5'd29},
        {8'd255, 2'd2, 5'd0},
        {8'd1,   2'd0, 5'd0},
        {8'd245, 2'd1, 5'd0},
        {8'd13,  2'd0, 5'd1},
        {8'd254, 2'd2, 5'd0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic seg(input logic [7:0] c, input int n, input logic tk,
                       input logic sd, input logic vl);
        seg_evts = 0;
        seg_first = 0;
        seg_kind = -1;
        seg_key = -1;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            code = c;
            code_vld = vl;
            ms_tick = tk;
            shdn_n = sd;
            @(posedge clk);
            #1;
            if (evt_vld) begin
                seg_evts++;
                if (seg_evts == 1) begin
                    seg_first = i;
                    seg_kind = int'(evt_kind);
                    seg_key = int'(evt_key);
                end
            end
        end
    endtask

    task automatic expect_evt(input string req, input int at, input int kind, input int key);
        check(seg_evts == 1, req, seg_evts, 1);
        check(seg_first == at, req, seg_first, at);
        check(seg_kind == kind, req, seg_kind, kind);
        check(seg_key == key, req, seg_key, key);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(evt_vld == 1'b0, "R8 reset strobe", int'(evt_vld), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: reported class after reset is jack absent, so open line is silent
        seg(8'd255, 30, 1'b1, 1'b1, 1'b1);
        check(seg_evts == 0, "R8 rest state", seg_evts, 0);

        // table: R1 R4 R6 R2 R7, event after the 19th edge of each segment
        for (int v = 0; v < 12; v++) begin
            seg(VEC[v][14:7], 25, 1'b1, 1'b1, 1'b1);
            expect_evt("R1/R4/R6 table", 19, int'(VEC[v][6:5]), int'(VEC[v][4:0]));
        end

        // R3: short excursion away from jack absent
        seg(8'd12, 10, 1'b1, 1'b1, 1'b1);
        seg(8'd255, 30, 1'b1, 1'b1, 1'b1);
        check(seg_evts == 0, "R3 chatter", seg_evts, 0);

        // R5: gap code alone never reports
        seg(8'd7, 40, 1'b1, 1'b1, 1'b1);
        check(seg_evts == 0, "R5 gap code", seg_evts, 0);

        // R5: gap sample mid-window restarts the count
        seg(8'd12, 10, 1'b1, 1'b1, 1'b1);
        check(seg_evts == 0, "R5 pre-gap", seg_evts, 0);
        seg(8'd7, 1, 1'b1, 1'b1, 1'b1);
        seg(8'd12, 25, 1'b1, 1'b1, 1'b1);
        expect_evt("R5 restart", 18, 0, 1);

        // R9: candidate switches to another key
        seg(8'd20, 10, 1'b1, 1'b1, 1'b1);
        seg(8'd125, 25, 1'b1, 1'b1, 1'b1);
        expect_evt("R9 new candidate", 19, 0, 15);

        // R2: samples without ticks do not qualify
        seg(8'd20, 50, 1'b0, 1'b1, 1'b1);
        check(seg_evts == 0, "R2 no ticks", seg_evts, 0);
        seg(8'd20, 25, 1'b1, 1'b1, 1'b0);
        expect_evt("R2 ticks only", 18, 0, 2);

        // R8: shutdown blocks events and restores jack absent
        seg(8'd243, 30, 1'b1, 1'b0, 1'b1);
        check(seg_evts == 0, "R8 shutdown quiet", seg_evts, 0);
        seg(8'd255, 30, 1'b1, 1'b1, 1'b1);
        check(seg_evts == 0, "R8 restored rest", seg_evts, 0);
        seg(8'd0, 25, 1'b1, 1'b1, 1'b1);
        expect_evt("R8 after resume", 19, 0, 0);

        // R8: shutdown pulse mid-window drops the count
        seg(8'd243, 10, 1'b1, 1'b1, 1'b1);
        seg(8'd243, 1, 1'b1, 1'b0, 1'b1);
        seg(8'd243, 25, 1'b1, 1'b1, 1'b1);
        expect_evt("R8 count lost", 20, 1, 0);

        finish_run();
    end

endmodule